// File: doc/BRIEF.md
# Network Controller Command and Status Register Unit

This block is the host-visible control point of a network controller. Software writes a 16-bit command word that carries two independent opcode fields: one for the transmit command engine and one for the receive engine. Each legal opcode is held in its field and offered to its engine over a valid/accept handshake. The field returns to zero when the engine takes the opcode, so software can poll the command word to learn that its request was consumed. A 32-bit pointer register, written beforehand, is captured together with each command. It travels to the engine as the operand of the address-carrying opcodes.

The 16-bit status word gathers hardware events in its upper byte and mirrors the state codes of both engines in its lower byte. Software clears events by writing ones to them. One interrupt line is raised while any event is pending, unless the mask bit in the command word is set. The engines, their descriptor handling and the PHY sit outside the block and drive only event pulses, state codes and accept strobes.

Register selection on the host port: address 0 is the status word (writes acknowledge events), address 1 is the command word, address 2 is the pointer, and address 3 is ignored.

Top module: `nic_ctl_regfile`

## Requirements
- R1: After reset the status word, the command word, both command valids and the interrupt are all zero.
- R2: A one on hw_evt[i] sets status bit 8+i at the next clock edge. Status bit 9 (hw_evt[1]) is reserved and always reads 0. Bit meanings are: 15 command done, 14 frame received, 13 command engine idle, 12 receiver not ready, 11 management cycle done, 10 software interrupt, 8 pause.
- R3: A write to address 0 clears every status bit in 15:8 where the written data holds a 1, so the effective acknowledge mask is 0xFD00. Bits written as 0 keep their value.
- R4: When a hardware event and an acknowledge of the same bit fall in one cycle, the bit ends up set.
- R5: Writing command bit 9 as 1 sets status bit 10. Command bit 9 always reads back 0.
- R6: irq_out is the OR of status bits 15:8, forced low while command bit 8 (the mask) is 1. It changes at the same edge as the status and command words.
- R7: A write of a legal transmit opcode to command bits 7:4 (1 start, 2 resume, 4 load statistics address, 5 dump statistics, 6 load base, 7 dump and reset) appears in those bits and on tx_cmd_op with tx_cmd_valid high. It stays there until a cycle with tx_cmd_accept high, after which bits 7:4 and tx_cmd_valid are 0.
- R8: A write of a legal receive opcode to command bits 2:0 (1 start, 2 resume, 4 abort, 6 load base, 7 resume without resources) behaves the same way on rx_cmd_valid, rx_cmd_op and rx_cmd_accept.
- R9: Undefined opcodes (transmit 3 and 8..15, receive 3 and 5) are ignored. The field stays 0 and no valid is raised.
- R10: A new opcode written while the same field is still pending is ignored. The other field is unaffected.
- R11: The pointer (address 2) is captured when a command is accepted into its field. The operand equals that pointer for transmit opcodes 1, 4 and 6 and for receive opcodes 1 and 6, and is 0 for all other opcodes. Later pointer writes do not change a pending operand.
- R12: ru_state_in appears in status bits 5:2 and cu_state_in in status bits 7:6 one clock after they are applied. The receive code is 0 idle, 1 suspended, 2 no resources, 4 ready, plus 8 when no buffer descriptors remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 2 | Register select: 0 status, 1 command, 2 pointer |
| host_wdata | input | 32 | Host write data |
| stat_word | output | 16 | Status word readback |
| cmd_word | output | 16 | Command word readback |
| ptr_word | output | 32 | Pointer register readback |
| hw_evt | input | 8 | Event pulses, index i maps to status bit 8+i |
| ru_state_in | input | 4 | Receive engine state code |
| cu_state_in | input | 2 | Transmit command engine state code |
| tx_cmd_valid | output | 1 | Transmit opcode pending |
| tx_cmd_op | output | 4 | Pending transmit opcode |
| tx_cmd_arg | output | 32 | Transmit opcode operand |
| tx_cmd_accept | input | 1 | Transmit engine takes the opcode |
| rx_cmd_valid | output | 1 | Receive opcode pending |
| rx_cmd_op | output | 3 | Pending receive opcode |
| rx_cmd_arg | output | 32 | Receive opcode operand |
| rx_cmd_accept | input | 1 | Receive engine takes the opcode |
| irq_out | output | 1 | Masked interrupt request |

## Verification
Every cycle, the assertions check these properties. A pending opcode and its operand hold steady until accepted, and an accept empties the field. Only legal opcodes ever reach an engine. An unacknowledged event never drops. A hardware event always lands. The interrupt never rises while masked. Some behaviour needs chosen stimulus and is shown only by the bench scenarios: the exact acknowledge mask, the same-cycle race between event and acknowledge, the pointer-to-operand selection per opcode, the refusal of a second command while one is pending, and the placement of the state codes.

// File: rtl/nic_ctl_pkg.sv
package nic_ctl_pkg;
  localparam int HOST_AW  = 2;
  localparam int WORD_W   = 16;
  localparam int EVT_N    = 8;
  localparam int CU_OP_W  = 4;
  localparam int RU_OP_W  = 3;
  localparam int RU_ST_W  = 4;
  localparam int CU_ST_W  = 2;

  // command word field positions (decoded by software and engines)
  localparam int CMD_RU_LSB   = 0;
  localparam int CMD_CU_LSB   = 4;
  localparam int CMD_MASK_BIT = 8;
  localparam int CMD_SWI_BIT  = 9;
  // status word layout
  localparam int STAT_EVT_LSB = 8;
  localparam int SWI_IDX      = 2;   // status bit 10

  typedef enum logic [HOST_AW-1:0] {
    SEL_STAT = 2'd0,
    SEL_CMD  = 2'd1,
    SEL_PTR  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // event bits that exist (status bit 9 reserved)
  localparam logic [EVT_N-1:0] EVT_KEEP = 8'hFD;

  // one bit per opcode value: legal codes and codes that carry the pointer
  localparam logic [(1<<CU_OP_W)-1:0] CU_LEGAL = 16'h00F6; // 1,2,4,5,6,7
  localparam logic [(1<<CU_OP_W)-1:0] CU_ARG   = 16'h0052; // 1,4,6
  localparam logic [(1<<RU_OP_W)-1:0] RU_LEGAL = 8'hD6;    // 1,2,4,6,7
  localparam logic [(1<<RU_OP_W)-1:0] RU_ARG   = 8'h42;    // 1,6
endpackage

// File: rtl/nic_cmd_slot.sv
module nic_cmd_slot #(
  parameter int OP_W  = 4,
  parameter int ARG_W = 32,
  parameter logic [(1<<OP_W)-1:0] LEGAL   = '0,
  parameter logic [(1<<OP_W)-1:0] ARG_SEL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_req,
  input  logic [OP_W-1:0]  wr_op,
  input  logic [ARG_W-1:0] ptr_in,
  input  logic             accept,
  output logic             valid,
  output logic [OP_W-1:0]  op_q,
  output logic [ARG_W-1:0] arg_q
);
  logic legal_w;
  logic busy_w;

  assign legal_w = (wr_op != '0) && LEGAL[wr_op];
  assign busy_w  = (op_q != '0);
  assign valid   = busy_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q  <= '0;
      arg_q <= '0;
    end else if (!busy_w) begin
      if (wr_req && legal_w) begin
        op_q  <= wr_op;
        arg_q <= ARG_SEL[wr_op] ? ptr_in : '0;
      end
    end else if (accept) begin
      op_q <= '0;
    end
  end
endmodule

// File: rtl/nic_evt_bank.sv
module nic_evt_bank #(
  parameter int N = 8,
  parameter logic [N-1:0] KEEP = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] hw_set,
  input  logic [N-1:0] sw_set,
  input  logic         ack_we,
  input  logic [N-1:0] ack_bits,
  input  logic         mask_nxt,
  output logic [N-1:0] evt_q,
  output logic         irq_q
);
  logic [N-1:0] clr_w;
  logic [N-1:0] evt_nxt;

  assign clr_w   = ack_we ? ack_bits : '0;
  // setting after clearing: a same-cycle event survives its acknowledge
  assign evt_nxt = ((evt_q & ~clr_w) | hw_set | sw_set) & KEEP;

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      evt_q <= evt_nxt;
      irq_q <= (|evt_nxt) & ~mask_nxt;
    end
  end
endmodule

// File: rtl/nic_state_reg.sv
module nic_state_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/nic_ctl_regfile.sv
module nic_ctl_regfile
  import nic_ctl_pkg::*;
#(
  parameter int PTR_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_we,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [PTR_W-1:0]   host_wdata,
  output logic [WORD_W-1:0]  stat_word,
  output logic [WORD_W-1:0]  cmd_word,
  output logic [PTR_W-1:0]   ptr_word,
  input  logic [EVT_N-1:0]   hw_evt,
  input  logic [RU_ST_W-1:0] ru_state_in,
  input  logic [CU_ST_W-1:0] cu_state_in,
  output logic               tx_cmd_valid,
  output logic [CU_OP_W-1:0] tx_cmd_op,
  output logic [PTR_W-1:0]   tx_cmd_arg,
  input  logic               tx_cmd_accept,
  output logic               rx_cmd_valid,
  output logic [RU_OP_W-1:0] rx_cmd_op,
  output logic [PTR_W-1:0]   rx_cmd_arg,
  input  logic               rx_cmd_accept,
  output logic               irq_out
);
  localparam int LOW_PAD = WORD_W - CU_ST_W - RU_ST_W - EVT_N;

  logic wr_stat, wr_cmd, wr_ptr;
  logic mask_q, mask_nxt;
  logic [PTR_W-1:0]   ptr_q;
  logic [EVT_N-1:0]   sw_set;
  logic [EVT_N-1:0]   evt_q;
  logic [RU_ST_W-1:0] ru_st_q;
  logic [CU_ST_W-1:0] cu_st_q;

  assign wr_stat = host_we && (reg_sel_e'(host_addr) == SEL_STAT);
  assign wr_cmd  = host_we && (reg_sel_e'(host_addr) == SEL_CMD);
  assign wr_ptr  = host_we && (reg_sel_e'(host_addr) == SEL_PTR);

  assign mask_nxt = wr_cmd ? host_wdata[CMD_MASK_BIT] : mask_q;

  always_comb begin
    sw_set          = '0;
    sw_set[SWI_IDX] = wr_cmd && host_wdata[CMD_SWI_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q  <= '0;
      mask_q <= 1'b0;
    end else begin
      if (wr_ptr) ptr_q <= host_wdata;
      mask_q <= mask_nxt;
    end
  end

  nic_cmd_slot #(
    .OP_W(CU_OP_W), .ARG_W(PTR_W), .LEGAL(CU_LEGAL), .ARG_SEL(CU_ARG)
  ) cu_slot_i (
    .clk(clk), .rst(rst),
    .wr_req(wr_cmd),
    .wr_op(host_wdata[CMD_CU_LSB +: CU_OP_W]),
    .ptr_in(ptr_q),
    .accept(tx_cmd_accept),
    .valid(tx_cmd_valid),
    .op_q(tx_cmd_op),
    .arg_q(tx_cmd_arg)
  );

  nic_cmd_slot #(
    .OP_W(RU_OP_W), .ARG_W(PTR_W), .LEGAL(RU_LEGAL), .ARG_SEL(RU_ARG)
  ) ru_slot_i (
    .clk(clk), .rst(rst),
    .wr_req(wr_cmd),
    .wr_op(host_wdata[CMD_RU_LSB +: RU_OP_W]),
    .ptr_in(ptr_q),
    .accept(rx_cmd_accept),
    .valid(rx_cmd_valid),
    .op_q(rx_cmd_op),
    .arg_q(rx_cmd_arg)
  );

  nic_evt_bank #(.N(EVT_N), .KEEP(EVT_KEEP)) evt_i (
    .clk(clk), .rst(rst),
    .hw_set(hw_evt),
    .sw_set(sw_set),
    .ack_we(wr_stat),
    .ack_bits(host_wdata[STAT_EVT_LSB +: EVT_N]),
    .mask_nxt(mask_nxt),
    .evt_q(evt_q),
    .irq_q(irq_out)
  );

  nic_state_reg #(.W(RU_ST_W)) ru_st_i (.clk(clk), .rst(rst), .d(ru_state_in), .q(ru_st_q));
  nic_state_reg #(.W(CU_ST_W)) cu_st_i (.clk(clk), .rst(rst), .d(cu_state_in), .q(cu_st_q));

  assign stat_word = {evt_q, cu_st_q, ru_st_q, {LOW_PAD{1'b0}}};
  assign cmd_word  = {6'b0, 1'b0, mask_q, tx_cmd_op, 1'b0, rx_cmd_op};
  assign ptr_word  = ptr_q;
endmodule

// File: rtl/nic_ctl_regfile_chk.sv
module nic_ctl_regfile_chk (
  input logic        clk,
  input logic        rst,
  input logic        host_we,
  input logic [1:0]  host_addr,
  input logic [15:0] stat_word,
  input logic [15:0] cmd_word,
  input logic [7:0]  hw_evt,
  input logic        tx_cmd_valid,
  input logic [3:0]  tx_cmd_op,
  input logic [31:0] tx_cmd_arg,
  input logic        tx_cmd_accept,
  input logic        rx_cmd_valid,
  input logic [2:0]  rx_cmd_op,
  input logic [31:0] rx_cmd_arg,
  input logic        rx_cmd_accept,
  input logic        irq_out
);
  // R7 / R10 / R11: pending transmit command holds until taken
  a_r7_tx_hold: assert property (@(posedge clk) disable iff (rst)
    tx_cmd_valid && !tx_cmd_accept |=> tx_cmd_valid && $stable(tx_cmd_op) && $stable(tx_cmd_arg));
  a_r7_tx_drop: assert property (@(posedge clk) disable iff (rst)
    tx_cmd_valid && tx_cmd_accept |=> !tx_cmd_valid && (cmd_word[7:4] == 4'd0));
  // R8: same for receive
  a_r8_rx_hold: assert property (@(posedge clk) disable iff (rst)
    rx_cmd_valid && !rx_cmd_accept |=> rx_cmd_valid && $stable(rx_cmd_op) && $stable(rx_cmd_arg));
  a_r8_rx_drop: assert property (@(posedge clk) disable iff (rst)
    rx_cmd_valid && rx_cmd_accept |=> !rx_cmd_valid && (cmd_word[2:0] == 3'd0));
  // R9: only defined opcodes reach the engines
  a_r9_tx_legal: assert property (@(posedge clk) disable iff (rst)
    tx_cmd_valid |-> (tx_cmd_op inside {4'd1, 4'd2, 4'd4, 4'd5, 4'd6, 4'd7}));
  a_r9_rx_legal: assert property (@(posedge clk) disable iff (rst)
    rx_cmd_valid |-> (rx_cmd_op inside {3'd1, 3'd2, 3'd4, 3'd6, 3'd7}));
  // R3: without a status write no pending event disappears
  a_r3_no_silent_clear: assert property (@(posedge clk) disable iff (rst)
    !(host_we && host_addr == 2'd0) |=>
      ((stat_word[15:8] & $past(stat_word[15:8])) == $past(stat_word[15:8])));
  // R4: a hardware event always lands
  a_r4_event_wins: assert property (@(posedge clk) disable iff (rst)
    hw_evt[7] |=> stat_word[15]);
  // R6: never an interrupt while masked
  a_r6_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    cmd_word[8] |-> !irq_out);
endmodule

bind nic_ctl_regfile nic_ctl_regfile_chk chk_i (
  .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
  .stat_word(stat_word), .cmd_word(cmd_word), .hw_evt(hw_evt),
  .tx_cmd_valid(tx_cmd_valid), .tx_cmd_op(tx_cmd_op), .tx_cmd_arg(tx_cmd_arg),
  .tx_cmd_accept(tx_cmd_accept),
  .rx_cmd_valid(rx_cmd_valid), .rx_cmd_op(rx_cmd_op), .rx_cmd_arg(rx_cmd_arg),
  .rx_cmd_accept(rx_cmd_accept), .irq_out(irq_out)
);

// File: tb/nic_ctl_regfile_tb_top.sv
module nic_ctl_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_we = 1'b0;
  logic [1:0]  host_addr = 2'd0;
  logic [31:0] host_wdata = '0;
  logic [15:0] stat_word, cmd_word;
  logic [31:0] ptr_word;
  logic [7:0]  hw_evt = '0;
  logic [3:0]  ru_state_in = '0;
  logic [1:0]  cu_state_in = '0;
  logic        tx_cmd_valid, rx_cmd_valid, irq_out;
  logic [3:0]  tx_cmd_op;
  logic [2:0]  rx_cmd_op;
  logic [31:0] tx_cmd_arg, rx_cmd_arg;
  logic        tx_cmd_accept = 1'b0;
  logic        rx_cmd_accept = 1'b0;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  nic_ctl_regfile dut_i (
    .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .stat_word(stat_word), .cmd_word(cmd_word),
    .ptr_word(ptr_word), .hw_evt(hw_evt), .ru_state_in(ru_state_in),
    .cu_state_in(cu_state_in), .tx_cmd_valid(tx_cmd_valid),
    .tx_cmd_op(tx_cmd_op), .tx_cmd_arg(tx_cmd_arg),
    .tx_cmd_accept(tx_cmd_accept), .rx_cmd_valid(rx_cmd_valid),
    .rx_cmd_op(rx_cmd_op), .rx_cmd_arg(rx_cmd_arg),
    .rx_cmd_accept(rx_cmd_accept), .irq_out(irq_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // inputs change at falling edges; results are read at the next falling edge
  task automatic host_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0; host_wdata = '0;
  endtask

  task automatic pulse_evt(input logic [7:0] e);
    @(negedge clk); hw_evt = e;
    @(negedge clk); hw_evt = '0;
  endtask

  task automatic accept_tx;
    @(negedge clk); tx_cmd_accept = 1'b1;
    @(negedge clk); tx_cmd_accept = 1'b0;
  endtask

  task automatic accept_rx;
    @(negedge clk); rx_cmd_accept = 1'b1;
    @(negedge clk); rx_cmd_accept = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 status", stat_word, 32'h0);
    chk("R1 command", cmd_word, 32'h0);
    chk("R1 tx valid", tx_cmd_valid, 1'b0);
    chk("R1 rx valid", rx_cmd_valid, 1'b0);
    chk("R1 irq", irq_out, 1'b0);
  endtask

  task automatic t_events;
    pulse_evt(8'hFF);
    chk("R2 all events, bit 9 reserved", stat_word, 32'hFD00);
    chk("R6 irq on pending", irq_out, 1'b1);
    host_write(2'd0, 32'h0000_0500);
    chk("R3 ack bits 10 and 8", stat_word, 32'hF800);
    host_write(2'd0, 32'h0000_0000);
    chk("R3 zero ack keeps", stat_word, 32'hF800);
    host_write(2'd0, 32'h0000_FFFF);
    chk("R3 full ack", stat_word, 32'h0);
    chk("R6 irq clears", irq_out, 1'b0);
  endtask

  task automatic t_race;
    @(negedge clk);
    hw_evt = 8'h40; host_we = 1'b1; host_addr = 2'd0; host_wdata = 32'h0000_4000;
    @(negedge clk);
    hw_evt = '0; host_we = 1'b0; host_wdata = '0;
    chk("R4 event beats ack", stat_word, 32'h4000);
    host_write(2'd0, 32'h0000_4000);
    chk("R3 later ack clears", stat_word, 32'h0);
  endtask

  task automatic t_swi_mask;
    host_write(2'd1, 32'h0000_0100);
    chk("R6 mask readback", cmd_word, 32'h0100);
    pulse_evt(8'h80);
    chk("R2 command done event", stat_word, 32'h8000);
    chk("R6 masked irq low", irq_out, 1'b0);
    host_write(2'd1, 32'h0000_0200);
    chk("R5 software event", stat_word, 32'h8400);
    chk("R5 bit 9 reads 0", cmd_word, 32'h0);
    chk("R6 unmasked irq", irq_out, 1'b1);
    host_write(2'd0, 32'h0000_FFFF);
    chk("R6 irq after ack", irq_out, 1'b0);
  endtask

  task automatic t_cu;
    host_write(2'd2, 32'h1234_5678);
    host_write(2'd1, 32'h0000_0010);
    chk("R7 field readback", cmd_word, 32'h0010);
    chk("R7 tx valid", tx_cmd_valid, 1'b1);
    chk("R7 tx op", tx_cmd_op, 4'd1);
    chk("R11 start operand", tx_cmd_arg, 32'h1234_5678);
    host_write(2'd2, 32'hAAAA_0000);
    chk("R11 operand frozen", tx_cmd_arg, 32'h1234_5678);
    host_write(2'd1, 32'h0000_0050);
    chk("R10 pending not replaced", tx_cmd_op, 4'd1);
    accept_tx;
    chk("R7 field cleared", cmd_word, 32'h0);
    chk("R7 valid dropped", tx_cmd_valid, 1'b0);
    host_write(2'd1, 32'h0000_0050);
    chk("R7 dump op", tx_cmd_op, 4'd5);
    chk("R11 no operand for dump", tx_cmd_arg, 32'h0);
    accept_tx;
    host_write(2'd1, 32'h0000_0040);
    chk("R11 stats address operand", tx_cmd_arg, 32'hAAAA_0000);
    accept_tx;
  endtask

  task automatic t_ru;
    host_write(2'd2, 32'hCAFE_0001);
    host_write(2'd1, 32'h0000_0006);
    chk("R8 field readback", cmd_word, 32'h0006);
    chk("R8 rx valid", rx_cmd_valid, 1'b1);
    chk("R11 load base operand", rx_cmd_arg, 32'hCAFE_0001);
    accept_rx;
    chk("R8 field cleared", cmd_word, 32'h0);
    host_write(2'd1, 32'h0000_0004);
    chk("R8 abort op", rx_cmd_op, 3'd4);
    chk("R11 abort no operand", rx_cmd_arg, 32'h0);
    accept_rx;
    chk("R8 valid dropped", rx_cmd_valid, 1'b0);
  endtask

  task automatic t_illegal;
    host_write(2'd1, 32'h0000_0030);
    chk("R9 tx code 3", cmd_word, 32'h0);
    chk("R9 tx valid low", tx_cmd_valid, 1'b0);
    host_write(2'd1, 32'h0000_0085);
    chk("R9 tx 8 rx 5", cmd_word, 32'h0);
    host_write(2'd1, 32'h0000_00F3);
    chk("R9 tx 15 rx 3", cmd_word, 32'h0);
    chk("R9 rx valid low", rx_cmd_valid, 1'b0);
  endtask

  task automatic t_both;
    host_write(2'd2, 32'h0BAD_F00D);
    host_write(2'd1, 32'h0000_0021);
    chk("R7 R8 both pending", cmd_word, 32'h0021);
    chk("R11 resume no operand", tx_cmd_arg, 32'h0);
    chk("R11 rx start operand", rx_cmd_arg, 32'h0BAD_F00D);
    host_write(2'd1, 32'h0000_0017);
    chk("R10 both pending, writes ignored", cmd_word, 32'h0021);
    accept_rx;
    chk("R8 rx only taken", cmd_word, 32'h0020);
    accept_tx;
    chk("R7 tx taken", cmd_word, 32'h0);
  endtask

  task automatic t_state;
    @(negedge clk); ru_state_in = 4'd12; cu_state_in = 2'd2;
    @(negedge clk);
    chk("R12 state codes", stat_word, 32'h00B0);
    ru_state_in = 4'd1; cu_state_in = 2'd1;
    @(negedge clk);
    chk("R12 suspended", stat_word, 32'h0044);
    ru_state_in = 4'd0; cu_state_in = 2'd0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_events;
    t_race;
    t_swi_mask;
    t_cu;
    t_ru;
    t_illegal;
    t_both;
    t_state;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule